// File: doc/BRIEF.md
# Dual-Timeout Watchdog Timer

This block watches a kick line driven by a processor and raises a one-cycle expire pulse when the line stops changing for too long. A change in either direction counts as a kick. The kick line is asynchronous to the block clock, so it passes through a synchronizer, and edges are found on the synchronized value.

Two timeouts are used, both given in clock cycles as parameters. After every release from reset, the block enters a boot phase with a long timeout, so software has time to start before it must kick. The first kick edge ends the boot phase. From then on the shorter run timeout applies, and each kick edge restarts the count.

A system reset sequencer drives two inputs. One is a hold level that keeps the timer cleared and silent while reset is active. The other is a one-cycle release strobe that starts a new boot phase. After the block expires it stays idle until the sequencer holds or releases it again.

Top module: `wdt_dual_timeout`

## Requirements
- R1: After the synchronous reset `rst`, `expire_o` is 0 and stays 0 for any length of time and any kick activity, until a release strobe is sampled.
- R2: With `release_i` sampled high at clock edge E and no kick edge after it, `expire_o` is 1 in exactly the cycle after edge E+BOOT_TICKS and 0 in every earlier cycle.
- R3: A kick edge in the boot phase ends that phase. If `kick_i` changes just before clock edge k and no further change follows, `expire_o` is 1 in the cycle after edge k+2+NORM_TICKS (two synchronizer stages).
- R4: Both a 0-to-1 and a 1-to-0 change of `kick_i` restart the running count. Kicks spaced closer than NORM_TICKS never produce an expiry.
- R5: `expire_o` is high for exactly one cycle. After it, the block is idle: no further pulse occurs, whatever `kick_i` does, until `hold_i` or `release_i` is seen.
- R6: While `hold_i` is 1, `expire_o` is 0 in the following cycle and `release_i` is ignored. When `hold_i` falls, the block stays silent until a release strobe arrives.
- R7: A release strobe after an expiry starts a new boot phase, using the BOOT_TICKS timeout again.
- R8: A release strobe during the run phase restarts the boot phase, so the next expiry comes BOOT_TICKS cycles after it, not NORM_TICKS cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset; the block starts held |
| kick_i | input | 1 | Asynchronous kick line from the processor |
| hold_i | input | 1 | Level, high while system reset is active |
| release_i | input | 1 | One-cycle strobe when system reset is released |
| expire_o | output | 1 | One-cycle pulse requesting a system reset |

## Verification
Some states are hard to reach from the ports: a run-phase timer that a fresh release must pull back into the boot phase, and an expired block that must ignore kicks. The stimulus gets there in steps. It releases the block, kicks once to enter the run phase, then releases again partway through the short window. It also lets the boot window lapse and then toggles the kick line through the idle period. Timing is measured as an exact cycle count from the stimulus edge. That count includes the two synchronizer stages, so a missed or extra restart changes the measured number.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    PH_HELD = 2'd0,
    PH_BOOT = 2'd1,
    PH_RUN  = 2'd2,
    PH_DONE = 2'd3
  } wdt_phase_e;
endpackage

// File: rtl/wdt_kick_sync.sv
module wdt_kick_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic kick_i,
  output logic edge_o
);
  logic [SYNC_STAGES-1:0] sh_q;
  logic                   prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[SYNC_STAGES-2:0], kick_i};
      prev_q <= sh_q[SYNC_STAGES-1];
    end
  end

  // any change of the synchronized level is a kick
  assign edge_o = sh_q[SYNC_STAGES-1] ^ prev_q;
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_i,
  input  logic          run_i,
  output logic [CW-1:0] count_o
);
  always_ff @(posedge clk) begin
    if (rst || clear_i) count_o <= '0;
    else if (run_i)     count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int CW = 8,
  parameter logic [CW-1:0] BOOT_LAST = '1,
  parameter logic [CW-1:0] NORM_LAST = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold_i,
  input  logic          release_i,
  input  logic          kick_edge_i,
  input  logic [CW-1:0] count_i,
  output wdt_phase_e    phase_o,
  output logic          clear_o,
  output logic          run_o,
  output logic          expire_o
);
  wdt_phase_e phase_d;
  logic       active, hit;

  assign active = (phase_o == PH_BOOT) || (phase_o == PH_RUN);
  assign hit    = !kick_edge_i &&
                  (((phase_o == PH_BOOT) && (count_i == BOOT_LAST)) ||
                   ((phase_o == PH_RUN)  && (count_i == NORM_LAST)));
  assign run_o   = active;
  assign clear_o = hold_i || release_i || (active && (kick_edge_i || hit));

  always_comb begin
    phase_d = phase_o;
    if (hold_i)         phase_d = PH_HELD;
    else if (release_i) phase_d = PH_BOOT;
    else if (active && kick_edge_i) phase_d = PH_RUN;
    else if (hit)       phase_d = PH_DONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_o  <= PH_HELD;
      expire_o <= 1'b0;
    end else begin
      phase_o  <= phase_d;
      expire_o <= hit && !hold_i && !release_i;
    end
  end
endmodule

// File: rtl/wdt_dual_timeout.sv
module wdt_dual_timeout
  import wdt_pkg::*;
#(
  parameter longint unsigned BOOT_TICKS  = 64'd12_750_000_000,
  parameter longint unsigned NORM_TICKS  = 64'd400_000_000,
  parameter int              SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic kick_i,
  input  logic hold_i,
  input  logic release_i,
  output logic expire_o
);
  localparam int CW = $clog2(BOOT_TICKS);
  localparam logic [CW-1:0] BOOT_LAST = CW'(BOOT_TICKS - 1);
  localparam logic [CW-1:0] NORM_LAST = CW'(NORM_TICKS - 1);

  logic          kick_edge, clear, run;
  logic [CW-1:0] cnt;
  wdt_phase_e    phase;

  wdt_kick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .kick_i(kick_i), .edge_o(kick_edge)
  );

  wdt_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .clear_i(clear), .run_i(run), .count_o(cnt)
  );

  wdt_ctrl #(.CW(CW), .BOOT_LAST(BOOT_LAST), .NORM_LAST(NORM_LAST)) u_ctrl (
    .clk(clk), .rst(rst), .hold_i(hold_i), .release_i(release_i),
    .kick_edge_i(kick_edge), .count_i(cnt), .phase_o(phase),
    .clear_o(clear), .run_o(run), .expire_o(expire_o)
  );

  a_r5_one_cycle: assert property (@(posedge clk) disable iff (rst)
    expire_o |=> !expire_o);

  a_r6_hold_silent: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> !expire_o);

  a_r2_boot_bound: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_BOOT) |-> (cnt <= BOOT_LAST));

  a_r3_run_bound: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RUN) |-> (cnt <= NORM_LAST));

  a_r4_kick_restart: assert property (@(posedge clk) disable iff (rst)
    (kick_edge && ((phase == PH_BOOT) || (phase == PH_RUN))) |=> (cnt == '0));

  a_r5_done_quiet: assert property (@(posedge clk) disable iff (rst)
    ((phase == PH_DONE) && !hold_i && !release_i) |=> (!expire_o && (phase == PH_DONE)));
endmodule

// File: tb/tb_wdt_dual_timeout.sv
module tb_wdt_dual_timeout;
  localparam int BOOT = 200;
  localparam int NORM = 40;
  localparam int KICK_LAT = 3;

  logic clk = 1'b0, rst = 1'b1, kick = 1'b0, hold = 1'b0, rel = 1'b0;
  logic expire;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  wdt_dual_timeout #(.BOOT_TICKS(BOOT), .NORM_TICKS(NORM)) dut (
    .clk(clk), .rst(rst), .kick_i(kick), .hold_i(hold),
    .release_i(rel), .expire_o(expire)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // counts negedges from start_c to max; first pulse position and pulse count
  task automatic measure(input int start_c, input int max, output int first, output int pulses);
    first = 0; pulses = 0;
    for (int c = start_c; c <= max; c++) begin
      @(negedge clk);
      if (expire) begin
        pulses++;
        if (first == 0) first = c;
      end
    end
  endtask

  task automatic release_pulse();
    rel = 1'b1;
    @(negedge clk);
    rel = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    int f, p;
    @(negedge clk);
    check(expire == 1'b0, "R1 reset value", expire, 0);
    rst = 1'b0;
    measure(1, 150, f, p);
    kick = ~kick;
    measure(1, 150, f, p);
    check(p == 0, "R1 no expiry before release", p, 0);
  endtask

  task automatic t_boot_timeout();
    int f, p;
    release_pulse();
    measure(2, BOOT + 60, f, p);
    check(f == BOOT + 1, "R2 boot timeout cycle", f, BOOT + 1);
    check(p == 1, "R5 single pulse", p, 1);
  endtask

  task automatic t_idle_after();
    int f, p;
    for (int i = 0; i < 4; i++) begin
      kick = ~kick;
      measure(1, 30, f, p);
      check(p == 0, "R5 idle ignores kicks", p, 0);
    end
  endtask

  task automatic t_rerelease();
    int f, p;
    release_pulse();
    measure(2, BOOT + 20, f, p);
    check(f == BOOT + 1, "R7 long timeout after expiry", f, BOOT + 1);
  endtask

  task automatic t_switch_normal();
    int f, p;
    release_pulse();
    idle(50);
    kick = ~kick;
    measure(1, NORM + 20, f, p);
    check(f == NORM + KICK_LAT, "R3 normal timeout after first kick", f, NORM + KICK_LAT);
    check(p == 1, "R5 one pulse in run phase", p, 1);
  endtask

  task automatic t_both_edges();
    int f, p;
    release_pulse();
    idle(20);
    for (int i = 0; i < 6; i++) begin
      kick = ~kick;
      measure(1, 30, f, p);
      check(p == 0, kick ? "R4 rising kick restarts" : "R4 falling kick restarts", p, 0);
    end
    kick = ~kick;
    measure(1, NORM + 10, f, p);
    check(f == NORM + KICK_LAT, "R4 expiry after last kick", f, NORM + KICK_LAT);
  endtask

  task automatic t_hold();
    int f, p;
    release_pulse();
    idle(30);
    hold = 1'b1;
    @(negedge clk);
    rel = 1'b1;
    @(negedge clk);
    rel = 1'b0;
    measure(1, BOOT + 20, f, p);
    check(p == 0, "R6 silent during hold", p, 0);
    hold = 1'b0;
    measure(1, BOOT + 20, f, p);
    check(p == 0, "R6 silent after hold until release", p, 0);
    release_pulse();
    measure(2, BOOT + 20, f, p);
    check(f == BOOT + 1, "R6 boot timeout after hold", f, BOOT + 1);
  endtask

  task automatic t_release_in_run();
    int f, p;
    release_pulse();
    idle(10);
    kick = ~kick;
    idle(20);
    release_pulse();
    measure(2, BOOT + 20, f, p);
    check(f == BOOT + 1, "R8 release restarts boot phase", f, BOOT + 1);
  endtask

  initial begin
    idle(3);
    t_reset();
    t_boot_timeout();
    t_idle_after();
    t_rerelease();
    t_switch_normal();
    t_both_edges();
    t_hold();
    t_release_in_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule